// File: doc/BRIEF.md
# Pseudo-Associative Hash-Rehash Cache Controller

This block is a small cache that gives every address two possible homes without building a two-way comparator array. The first slot it tries is the plain direct-mapped slot, so a hit there costs exactly what a direct-mapped cache costs. Only when that slot misses does the controller, one cycle later, try a second slot. It finds the second slot by inverting the most significant bit of the index. A hit in the second slot is promoted: it trades places with the line in the first slot, so the next access to it is fast.

When both probes miss, the controller reads a full line from memory into the first slot. The line that sat in the first slot moves down to the second slot, and the line that sat there is evicted. Each stored line carries a flag that says whether it sits in its home slot or in its alternate slot. That flag takes part in the tag compare, so two addresses that share a primary index can both stay resident. Write hits mark the line dirty. A dirty line is written back as a whole line before the refill that evicts it.

The processor raises `req_i` and holds `we_i`, `addr_i` and `wdata_i` steady until it sees `ready_o` high at a rising clock edge. Memory transfers are whole lines. `mem_req_o` stays high until a one-cycle `mem_ack_i` pulse arrives, and read data is taken from `mem_rdata_i` on that pulse.

Top module: `pac_cache`

## Requirements
- R1: On a hit in the primary slot (index = `addr_i[OFF_W+IDX_W-1:OFF_W]`, word = `addr_i[OFF_W-1:0]`), `ready_o` is high in the same cycle the request is presented. A read returns the stored word on `rdata_o`. A write stores `wdata_i` at that edge, and a later read returns it.
- R2: The second probe goes to the primary index with its most significant bit inverted. It happens only after a primary miss, in the following cycle. `ready_o` is low during the miss cycle and during the second probe.
- R3: A hit in the rehashed slot completes with `ready_o` high two cycles after the request is first presented. The two lines swap slots, so the next access to the same line is a primary hit. An access to the line that was displaced then becomes a rehash hit.
- R4: A line is reported as a hit only when both of these hold: its stored tag equals the address tag, and its placement flag matches the probe. The flag is 0 in the primary probe and 1 in the rehashed probe.
- R5: When both probes miss, one line read is issued at line address `addr_i >> OFF_W`. The new line goes into the primary slot, marked clean. A valid previous occupant of the primary slot moves to the rehashed slot with its placement flag inverted. With no writeback, the request completes 2 + L cycles after it is presented, where L is the number of cycles from the start of the memory request to the acknowledge.
- R6: If the primary slot is empty when both probes miss, the rehashed slot keeps its line.
- R7: If a refill is about to evict a valid dirty line from the rehashed slot, that line is first written as a full line to its own line address (`{tag, home index}`). The line read follows. A clean eviction causes no memory write.
- R8: `ready_o` is low whenever `mem_req_o` is high. `mem_req_o`, `mem_we_o` and `mem_addr_o` hold steady until `mem_ack_i`.
- R9: After reset every slot is empty, `mem_req_o` is low, and `ready_o` is high while no request is pending.
- R10: A write that misses in both probes first allocates the line by refill, then stores its word. It completes in the same number of cycles as a read miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid when ready_o is high |
| ready_o | output | 1 | Request completes at this edge |
| mem_req_o | output | 1 | Line transfer request, held until ack |
| mem_we_o | output | 1 | 1 = line writeback, 0 = line read |
| mem_addr_o | output | ADDR_W-OFF_W | Line address |
| mem_wdata_o | output | DATA_W<<OFF_W | Writeback line |
| mem_ack_i | input | 1 | One-cycle transfer acknowledge |
| mem_rdata_i | input | DATA_W<<OFF_W | Refill line, taken with mem_ack_i |

## Verification
The bench counts the cycles from the one in which a request is presented until `ready_o` is seen high, and compares the count with the expected latency for that case. A primary hit is due at 0 cycles and a rehash hit at 2. A clean miss is due at 2 + L cycles, and a dirty-eviction miss at 3 + 2L cycles, where L is the bench memory's latency and the extra cycle is the acknowledge turnaround between the two transfers. Outputs are sampled just after the falling edge. Inputs and memory responses change only at the falling edge, so every counted cycle reflects the state registered at the preceding rising edge. Data is compared with a shadow model of memory that the bench updates on processor writes. Writebacks are checked by their count, by their line address, and by reading the evicted line back.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE2 = 2'd1,
    ST_WBACK  = 2'd2,
    ST_REFILL = 2'd3
  } pac_state_e;
endpackage

// File: rtl/pac_addr_split.sv
module pac_addr_split #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  pidx_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [IDX_W-1:0] FLIP = IDX_W'(1) << (IDX_W - 1);

  assign off_o  = addr_i[OFF_W-1:0];
  assign pidx_o = addr_i[OFF_W+IDX_W-1:OFF_W];
  assign tag_o  = addr_i[ADDR_W-1:OFF_W+IDX_W];
  // rehash: invert index msb
  assign ridx_o = pidx_o ^ FLIP;
endmodule

// File: rtl/pac_probe_cmp.sv
module pac_probe_cmp #(
  parameter int TAG_W = 11,
  localparam int META_W = TAG_W + 3
) (
  input  logic [META_W-1:0] meta_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              want_alt_i,
  output logic              hit_o
);
  localparam int M_V = TAG_W + 2;
  localparam int M_A = TAG_W;

  assign hit_o = meta_i[M_V] && (meta_i[M_A] == want_alt_i) &&
                 (meta_i[TAG_W-1:0] == tag_i);
endmodule

// File: rtl/pac_line_store.sv
module pac_line_store #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 11,
  parameter int DATA_W = 32,
  localparam int SETS   = 1 << IDX_W,
  localparam int LINE_W = DATA_W << OFF_W,
  localparam int META_W = TAG_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [META_W-1:0] a_meta_o,
  output logic [LINE_W-1:0] a_line_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [META_W-1:0] b_meta_o,
  output logic [LINE_W-1:0] b_line_o,
  input  logic              wp_en_i,
  input  logic [IDX_W-1:0]  wp_idx_i,
  input  logic [META_W-1:0] wp_meta_i,
  input  logic [LINE_W-1:0] wp_line_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [META_W-1:0] wr_meta_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic              ww_en_i,
  input  logic [IDX_W-1:0]  ww_idx_i,
  input  logic [OFF_W-1:0]  ww_off_i,
  input  logic [DATA_W-1:0] ww_data_i
);
  localparam int M_D = TAG_W + 1;

  logic [META_W-1:0] meta_q [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign a_meta_o = meta_q[a_idx_i];
  assign a_line_o = line_q[a_idx_i];
  assign b_meta_o = meta_q[b_idx_i];
  assign b_line_o = line_q[b_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        meta_q[s] <= '0;
        line_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SETS; s++) begin
        if (wp_en_i && wp_idx_i == IDX_W'(s)) begin
          meta_q[s] <= wp_meta_i;
          line_q[s] <= wp_line_i;
        end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
          meta_q[s] <= wr_meta_i;
          line_q[s] <= wr_line_i;
        end else if (ww_en_i && ww_idx_i == IDX_W'(s)) begin
          meta_q[s][M_D] <= 1'b1;
          line_q[s][ww_off_i*DATA_W +: DATA_W] <= ww_data_i;
        end
      end
    end
  end
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic       hit1_i,
  input  logic       hit2_i,
  input  logic       p_valid_i,
  input  logic       r_valid_i,
  input  logic       r_dirty_i,
  input  logic       mem_ack_i,
  output pac_state_e state_o,
  output logic       ready_o,
  output logic       ww_en_o,
  output logic       swap_o,
  output logic       fill_o,
  output logic       mem_req_o,
  output logic       mem_we_o
);
  pac_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i && !hit1_i) state_d = ST_PROBE2;
      ST_PROBE2: begin
        if (hit2_i)                                 state_d = ST_IDLE;
        else if (p_valid_i && r_valid_i && r_dirty_i) state_d = ST_WBACK;
        else                                        state_d = ST_REFILL;
      end
      ST_WBACK:  if (mem_ack_i) state_d = ST_REFILL;
      ST_REFILL: if (mem_ack_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign state_o   = state_q;
  assign ready_o   = (state_q == ST_IDLE) && (!req_i || hit1_i);
  assign ww_en_o   = (state_q == ST_IDLE) && req_i && we_i && hit1_i;
  assign swap_o    = (state_q == ST_PROBE2) && hit2_i;
  assign fill_o    = (state_q == ST_REFILL) && mem_ack_i;
  assign mem_req_o = (state_q == ST_WBACK) || (state_q == ST_REFILL);
  assign mem_we_o  = (state_q == ST_WBACK);
endmodule

// File: rtl/pac_cache.sv
module pac_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         ready_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [ADDR_W-OFF_W-1:0]      mem_addr_o,
  output logic [(DATA_W<<OFF_W)-1:0]   mem_wdata_o,
  input  logic                         mem_ack_i,
  input  logic [(DATA_W<<OFF_W)-1:0]   mem_rdata_i
);
  localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W  = DATA_W << OFF_W;
  localparam int META_W  = TAG_W + 3;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int M_V     = TAG_W + 2;
  localparam int M_D     = TAG_W + 1;
  localparam int M_A     = TAG_W;

  logic [TAG_W-1:0]  tag;
  logic [IDX_W-1:0]  pidx, ridx;
  logic [OFF_W-1:0]  off;
  logic [META_W-1:0] meta_p, meta_r;
  logic [LINE_W-1:0] line_p, line_r;
  logic [1:0]        hit;
  pac_state_e        state;
  logic              ww_en, swap, fill;
  logic              in_idle, in_probe2;
  logic [META_W-1:0] wp_meta, wr_meta;
  logic [LINE_W-1:0] wp_line;
  logic [IDX_W-1:0]  victim_home;

  pac_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr_i (addr_i),
    .tag_o  (tag),
    .pidx_o (pidx),
    .ridx_o (ridx),
    .off_o  (off)
  );

  pac_line_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (pidx),
    .a_meta_o  (meta_p),
    .a_line_o  (line_p),
    .b_idx_i   (ridx),
    .b_meta_o  (meta_r),
    .b_line_o  (line_r),
    .wp_en_i   (swap | fill),
    .wp_idx_i  (pidx),
    .wp_meta_i (wp_meta),
    .wp_line_i (wp_line),
    .wr_en_i   (swap | (fill & meta_p[M_V])),
    .wr_idx_i  (ridx),
    .wr_meta_i (wr_meta),
    .wr_line_i (line_p),
    .ww_en_i   (ww_en),
    .ww_idx_i  (pidx),
    .ww_off_i  (off),
    .ww_data_i (wdata_i)
  );

  // probe 0 = primary slot (flag 0), probe 1 = rehashed slot (flag 1)
  for (genvar g = 0; g < 2; g++) begin : g_probe
    pac_probe_cmp #(.TAG_W(TAG_W)) u_cmp (
      .meta_i     ((g == 0) ? meta_p : meta_r),
      .tag_i      (tag),
      .want_alt_i (g != 0),
      .hit_o      (hit[g])
    );
  end

  pac_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .hit1_i    (hit[0]),
    .hit2_i    (hit[1]),
    .p_valid_i (meta_p[M_V]),
    .r_valid_i (meta_r[M_V]),
    .r_dirty_i (meta_r[M_D]),
    .mem_ack_i (mem_ack_i),
    .state_o   (state),
    .ready_o   (ready_o),
    .ww_en_o   (ww_en),
    .swap_o    (swap),
    .fill_o    (fill),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o)
  );

  assign in_idle   = (state == ST_IDLE);
  assign in_probe2 = (state == ST_PROBE2);

  // promoted or refilled line always lands in the primary slot with flag 0
  assign wp_meta = swap ? {1'b1, meta_r[M_D], 1'b0, meta_r[TAG_W-1:0]}
                        : {1'b1, 1'b0, 1'b0, tag};
  assign wp_line = swap ? line_r : mem_rdata_i;
  // old primary occupant drops to the rehashed slot with its flag inverted
  assign wr_meta = {meta_p[M_V], meta_p[M_D], ~meta_p[M_A], meta_p[TAG_W-1:0]};

  assign victim_home = meta_r[M_A] ? pidx : ridx;
  assign mem_addr_o  = mem_we_o ? {meta_r[TAG_W-1:0], victim_home} : {tag, pidx};
  assign mem_wdata_o = line_r;
  assign rdata_o     = line_p[off*DATA_W +: DATA_W];

  logic [LADDR_W-1:0] unused_laddr;
  assign unused_laddr = mem_addr_o;
endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
  parameter int LADDR_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               ready_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic               mem_ack_i,
  input logic [LADDR_W-1:0] mem_addr_o,
  input logic               in_idle,
  input logic               in_probe2
);
  AST_NO_READY_DURING_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o); // R8
  AST_MEM_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o); // R8
  AST_MEM_CMD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o))); // R8
  AST_PROBE2_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_probe2 |-> !ready_o); // R2
  AST_MISS_GOES_PROBE2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && req_i && !ready_o) |=> in_probe2); // R2
  AST_WBACK_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> (mem_req_o && !mem_we_o)); // R7
  AST_REFILL_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> in_idle); // R5
endmodule

bind pac_cache pac_cache_chk #(.LADDR_W(LADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ready_o    (ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .in_idle    (in_idle),
  .in_probe2  (in_probe2)
);

// File: tb/pac_cache_test.sv
module pac_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int W_HIT      = 0;
  localparam int W_REHASH   = 2;
  localparam int W_MISS     = 2 + LAT;
  localparam int W_DIRTY    = 3 + 2 * LAT;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [15:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         ready;
  logic         mem_req, mem_we;
  logic [13:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int wb_count = 0;
  logic [13:0] wb_last = '0;
  logic [31:0] bmem [int];
  logic [31:0] shadow [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  pac_cache uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [31:0] pat(int a);
    return 32'h5A00_0000 + a * 32'h0001_0011;
  endfunction
  function automatic logic [31:0] mem_word(int a);
    return bmem.exists(a) ? bmem[a] : pat(a);
  endfunction
  function automatic logic [31:0] ref_word(int a);
    return shadow.exists(a) ? shadow[a] : pat(a);
  endfunction
  function automatic logic [15:0] mk(int t, int i, int o);
    return {t[10:0], i[2:0], o[1:0]};
  endfunction

  // memory model: ack LAT cycles after the request is seen
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        cnt++;
        if (cnt == LAT) begin
          mem_ack = 1'b1;
          for (int w = 0; w < 4; w++) begin
            if (mem_we) bmem[int'(mem_addr) * 4 + w] = mem_wdata[w*32 +: 32];
            else mem_rdata[w*32 +: 32] = mem_word(int'(mem_addr) * 4 + w);
          end
          if (mem_we) begin
            wb_count++;
            wb_last = mem_addr;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(bit w, logic [15:0] a, logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; waits = 0;
    #1;
    while (!ready && waits < 100) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(logic [15:0] a, int exp_w, string rq);
    logic [31:0] rd;
    int waits;
    access(1'b0, a, '0, rd, waits);
    check(waits == exp_w, rq, $sformatf("read %h latency", a), waits, exp_w);
    check(rd == ref_word(int'(a)), rq, $sformatf("read %h data", a), rd, ref_word(int'(a)));
  endtask

  task automatic wr_chk(logic [15:0] a, logic [31:0] d, int exp_w, string rq);
    logic [31:0] rd;
    int waits;
    access(1'b1, a, d, rd, waits);
    shadow[int'(a)] = d;
    check(waits == exp_w, rq, $sformatf("write %h latency", a), waits, exp_w);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(ready == 1'b1, "R9", "ready idle after reset", ready, 1);
    check(mem_req == 1'b0, "R9", "no memory request after reset", mem_req, 0);
  endtask

  task automatic t_primary();
    rd_chk(mk(1, 1, 0), W_MISS, "R5 cold miss");
    rd_chk(mk(1, 1, 2), W_HIT, "R1 primary hit");
  endtask

  task automatic t_conflict();
    rd_chk(mk(2, 1, 1), W_MISS, "R5 colliding miss");
    rd_chk(mk(2, 1, 3), W_HIT, "R1 new line primary");
    rd_chk(mk(1, 1, 3), W_REHASH, "R2 R3 rehash hit on idx^msb");
    rd_chk(mk(1, 1, 0), W_HIT, "R3 promoted line");
    rd_chk(mk(2, 1, 1), W_REHASH, "R3 displaced line in rehash slot");
    rd_chk(mk(2, 1, 0), W_HIT, "R3 swapped back");
  endtask

  task automatic t_write_hit();
    wr_chk(mk(2, 1, 2), 32'hDEAD_BEEF, W_HIT, "R1 write hit");
    rd_chk(mk(2, 1, 2), W_HIT, "R1 write readback");
  endtask

  task automatic t_dirty_evict();
    rd_chk(mk(4, 1, 0), W_MISS, "R7 clean eviction no writeback");
    check(wb_count == 0, "R7", "writebacks after clean eviction", wb_count, 0);
    rd_chk(mk(5, 1, 1), W_DIRTY, "R7 dirty eviction");
    check(wb_count == 1, "R7", "writeback count", wb_count, 1);
    check(wb_last == mk(2, 1, 0) >> 2, "R7", "writeback line address", wb_last, mk(2, 1, 0) >> 2);
    rd_chk(mk(2, 1, 2), W_MISS, "R7 evicted dirty data restored");
  endtask

  task automatic t_flag();
    rd_chk(mk(3, 5, 0), W_MISS, "R5 miss moves rehash-resident line home");
    rd_chk(mk(5, 1, 1), W_HIT, "R4 R5 moved line hits primary with flag 0");
    rd_chk(mk(5, 5, 2), W_MISS, "R4 same tag wrong flag is a miss");
    rd_chk(mk(3, 5, 3), W_REHASH, "R4 flag 1 rehash hit");
  endtask

  task automatic t_empty_primary();
    rd_chk(mk(6, 6, 1), W_MISS, "R5 fill empty slot");
    rd_chk(mk(7, 2, 2), W_MISS, "R6 miss with empty primary");
    rd_chk(mk(6, 6, 0), W_HIT, "R6 rehash slot kept its line");
    rd_chk(mk(7, 2, 0), W_HIT, "R6 new line primary");
  endtask

  task automatic t_write_miss();
    wr_chk(mk(8, 3, 1), 32'h1234_5678, W_MISS, "R10 write miss allocates");
    rd_chk(mk(8, 3, 1), W_HIT, "R10 written word");
    rd_chk(mk(8, 3, 0), W_HIT, "R10 rest of line from memory");
    check(wb_count == 1, "R7", "no extra writebacks", wb_count, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_primary();
    t_conflict();
    t_write_hit();
    t_dirty_evict();
    t_flag();
    t_empty_primary();
    t_write_miss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule